// File: doc/BRIEF.md
# Debug Run-Control and Breakpoint Unit

This unit decides, slot by slot, whether a simple in-order core may execute the instruction at the current program counter. A debug host steers it with a control write that carries a halt bit and a step bit. The unit also takes a programmable step length and add and remove strobes for a small table of hardware breakpoint addresses. The core presents `pc` together with a `slot_valid` strobe and receives `exec_en` for that same slot. When the core executes a software breakpoint instruction it reports this on `sw_bp_hit`.

The unit has four named states. OFF is held while `rst_n` is low. HALTED executes nothing. RUN executes every slot. STEP executes slots until an absolute step target is reached. The transitions are:
- OFF→HALTED on the first clock after reset release.
- HALTED/RUN/STEP→HALTED on a control write with the halt bit set.
- →STEP on a control write with only the step bit set.
- →RUN on a control write with neither bit set.
- RUN/STEP→HALTED when a breakpoint hits, a software breakpoint executes, or the step target is reached.

A breakpoint that has just stopped the core lets the very next checked slot at the same address through, once, so that the core can resume past it. The live retired-step counter is visible on `step_count`.

Top module: `dbg_runctl`

## Requirements
- R1: While `rst_n` is low the state is OFF: `stat_halt`=1, `exec_en`=0, `stat_sw_bp`=0, `stat_hw_bp`=0, `step_count`=0 and the breakpoint table is empty. On the first rising clock edge after release the state becomes HALTED.
- R2: A control write (`ctl_we`=1) decodes `ctl_halt` before `ctl_step`. If `ctl_halt`=1 the next state is HALTED. Otherwise, if `ctl_step`=1, the next state is STEP. Otherwise the next state is RUN.
- R3: A control write presented while the state is OFF has no effect; the unit still moves only to HALTED.
- R4: In OFF and HALTED, `exec_en` is 0 whatever `slot_valid` and `pc` are.
- R5: `step_count` is a 64-bit counter that increments by one in exactly those cycles where `exec_en`=1, and otherwise holds.
- R6: A control write that enters STEP sets the target to the step count after that cycle plus `step_len`. A STEP slot whose count is at or above the target does not execute and moves the state to HALTED. `step_len`=0 therefore halts at the first slot.
- R7: In RUN or STEP, a valid slot whose `pc` equals a stored breakpoint address does not execute. It records that address, sets `stat_hw_bp` and moves the state to HALTED.
- R8: The next checked slot whose `pc` equals the recorded address executes, once, and clears `stat_hw_bp`. A later slot at that address stops again.
- R9: `bp_add_we` stores `bp_add_addr` in the lowest free table entry. The table holds `BP_ENTRIES` (default 8) entries, and an add to a full table is dropped.
- R10: `bp_rm_we` frees only the lowest-indexed entry whose address equals `bp_rm_addr`. Any duplicate entries stay active.
- R11: `sw_bp_hit` in an executing slot sets `stat_sw_bp` and moves the state to HALTED. A later go or step control write clears `stat_sw_bp`.
- R12: `halt_evt` is 1 in exactly the cycle whose clock edge moves the state from RUN or STEP into HALTED, including on a halt control write. It is 0 on a halt write while the state is already HALTED.
- R13: When a control write and a slot-halting condition occur in the same cycle, the control write decides the next state. The slot itself still follows R6 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset; forces OFF |
| ctl_we | input | 1 | Control write strobe |
| ctl_halt | input | 1 | Halt bit of the control write |
| ctl_step | input | 1 | Step bit of the control write |
| step_len | input | CNT_W | Number of slots to execute when stepping |
| bp_add_we | input | 1 | Add-breakpoint strobe |
| bp_add_addr | input | ADDR_W | Address to add |
| bp_rm_we | input | 1 | Remove-breakpoint strobe |
| bp_rm_addr | input | ADDR_W | Address to remove |
| slot_valid | input | 1 | An instruction slot is offered this cycle |
| pc | input | ADDR_W | Address of the offered instruction |
| sw_bp_hit | input | 1 | The executing instruction is a software breakpoint |
| exec_en | output | 1 | The offered slot may execute |
| halt_evt | output | 1 | The state enters HALTED from RUN or STEP at the next edge |
| stat_halt | output | 1 | 1 when the state is OFF or HALTED |
| stat_sw_bp | output | 1 | Software breakpoint flag |
| stat_hw_bp | output | 1 | Hardware breakpoint flag |
| step_count | output | CNT_W | Live retired-step counter |

## Verification
The bench resumes at an address that has just stopped the core. A design without the one-shot pass would stall there forever, and one whose pass never expires would miss the same breakpoint on the next visit. Stepping is run both with a length of two and with a length of zero. An off-by-one target would execute one slot too many or too few, and a zero length would wrongly let a slot through. The table is filled to capacity, overfilled, loaded with duplicates and partly removed. A design that overwrote an entry when full or that cleared every matching entry would miss a later breakpoint. The bench also issues control writes in the off cycle and in the same cycle as a breakpoint hit. A design with the wrong priority would leave OFF early or stay halted.

// File: rtl/dbg_runctl_pkg.sv
package dbg_runctl_pkg;
    typedef enum logic [1:0] {
        RS_OFF    = 2'd0,
        RS_HALTED = 2'd1,
        RS_RUN    = 2'd2,
        RS_STEP   = 2'd3
    } run_state_e;
endpackage

// File: rtl/dbg_bp_table.sv
module dbg_bp_table #(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_we,
    input  logic [ADDR_W-1:0] add_addr,
    input  logic              rm_we,
    input  logic [ADDR_W-1:0] rm_addr,
    input  logic [ADDR_W-1:0] pc,
    output logic              hit
);
    localparam logic [ENTRIES-1:0] LSB_ONE = {{(ENTRIES-1){1'b0}}, 1'b1};

    logic [ENTRIES-1:0] vld_q;
    logic [ADDR_W-1:0]  addr_q [ENTRIES];
    logic [ENTRIES-1:0] pc_match;
    logic [ENTRIES-1:0] rm_match;
    logic [ENTRIES-1:0] free;
    logic [ENTRIES-1:0] free_sel;
    logic [ENTRIES-1:0] rm_sel;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        assign pc_match[i] = vld_q[i] && (addr_q[i] == pc);
        assign rm_match[i] = vld_q[i] && (addr_q[i] == rm_addr);
        assign free[i]     = !vld_q[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q[i]  <= 1'b0;
                addr_q[i] <= '0;
            end else if (add_we && free_sel[i]) begin
                vld_q[i]  <= 1'b1;
                addr_q[i] <= add_addr;
            end else if (rm_we && rm_sel[i]) begin
                vld_q[i]  <= 1'b0;
            end
        end
    end

    // lowest set bit picks the slot
    assign free_sel = free & (~free + LSB_ONE);
    assign rm_sel   = rm_match & (~rm_match + LSB_ONE);
    assign hit      = |pc_match;

    p_full_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (add_we && (&vld_q) && !rm_we) |=> (vld_q == $past(vld_q)));

    p_add_fills_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (add_we && !(&vld_q) && !rm_we)
        |=> ($countones(vld_q) == $countones($past(vld_q)) + 1));

    p_rm_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rm_we && (|rm_match) && !add_we)
        |=> ($countones(vld_q) + 1 == $countones($past(vld_q))));
endmodule

// File: rtl/dbg_step_ctr.sv
module dbg_step_ctr #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             arm,
    input  logic [CNT_W-1:0] step_len,
    output logic [CNT_W-1:0] count,
    output logic             reached
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] tgt_q;
    logic [CNT_W-1:0] count_nx;

    assign count_nx = inc ? (count_q + ONE) : count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            tgt_q   <= '0;
        end else begin
            count_q <= count_nx;
            if (arm) begin
                tgt_q <= count_nx + step_len;
            end
        end
    end

    assign count   = count_q;
    assign reached = (count_q >= tgt_q);

    p_count_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> (count_q == $past(count_q) + ONE));

    p_count_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(count_q));
endmodule

// File: rtl/dbg_runctl.sv
module dbg_runctl
    import dbg_runctl_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 64,
    parameter int BP_ENTRIES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              ctl_halt,
    input  logic              ctl_step,
    input  logic [CNT_W-1:0]  step_len,
    input  logic              bp_add_we,
    input  logic [ADDR_W-1:0] bp_add_addr,
    input  logic              bp_rm_we,
    input  logic [ADDR_W-1:0] bp_rm_addr,
    input  logic              slot_valid,
    input  logic [ADDR_W-1:0] pc,
    input  logic              sw_bp_hit,
    output logic              exec_en,
    output logic              halt_evt,
    output logic              stat_halt,
    output logic              stat_sw_bp,
    output logic              stat_hw_bp,
    output logic [CNT_W-1:0]  step_count
);
    run_state_e        state_q, state_d;
    logic              hw_flag_q, hw_flag_d;
    logic [ADDR_W-1:0] brk_q, brk_d;
    logic              sw_flag_q, sw_flag_d;

    logic active, step_reached, tbl_hit, pass_once, checked, bp_stop;
    logic slot_halt, ctl_ok, arm;

    dbg_bp_table #(.ADDR_W(ADDR_W), .ENTRIES(BP_ENTRIES)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .add_we   (bp_add_we),
        .add_addr (bp_add_addr),
        .rm_we    (bp_rm_we),
        .rm_addr  (bp_rm_addr),
        .pc       (pc),
        .hit      (tbl_hit)
    );

    dbg_step_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (exec_en),
        .arm      (arm),
        .step_len (step_len),
        .count    (step_count),
        .reached  (step_reached)
    );

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= RS_OFF;
            hw_flag_q <= 1'b0;
            brk_q     <= '0;
            sw_flag_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            hw_flag_q <= hw_flag_d;
            brk_q     <= brk_d;
            sw_flag_q <= sw_flag_d;
        end
    end

    // output and next-state process
    always_comb begin
        active    = (state_q == RS_RUN) || (state_q == RS_STEP);
        checked   = slot_valid && active &&
                    !((state_q == RS_STEP) && step_reached);
        pass_once = hw_flag_q && (pc == brk_q);
        bp_stop   = checked && tbl_hit && !pass_once;
        exec_en   = checked && !bp_stop;
        slot_halt = (slot_valid && active && !checked) || bp_stop ||
                    (exec_en && sw_bp_hit);
        ctl_ok    = ctl_we && (state_q != RS_OFF);
        arm       = ctl_ok && !ctl_halt && ctl_step;

        state_d = state_q;
        unique case (state_q)
            RS_OFF: state_d = RS_HALTED;
            RS_HALTED, RS_RUN, RS_STEP: begin
                if (ctl_ok) begin
                    if (ctl_halt)      state_d = RS_HALTED;
                    else if (ctl_step) state_d = RS_STEP;
                    else               state_d = RS_RUN;
                end else if (slot_halt) begin
                    state_d = RS_HALTED;
                end
            end
        endcase

        hw_flag_d = hw_flag_q;
        brk_d     = brk_q;
        if (checked) begin
            hw_flag_d = bp_stop;
            if (bp_stop) brk_d = pc;
        end

        sw_flag_d = sw_flag_q;
        if (ctl_ok && !ctl_halt)      sw_flag_d = 1'b0;
        else if (exec_en && sw_bp_hit) sw_flag_d = 1'b1;

        halt_evt   = active && (state_d == RS_HALTED);
        stat_halt  = (state_q == RS_OFF) || (state_q == RS_HALTED);
        stat_sw_bp = sw_flag_q;
        stat_hw_bp = hw_flag_q;
    end

    p_idle_no_exec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == RS_OFF) || (state_q == RS_HALTED)) |-> !exec_en);

    p_off_to_halt_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_OFF) |=> (state_q == RS_HALTED));

    p_step_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == RS_STEP) && step_reached) |-> !exec_en);

    p_bp_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && active && !ctl_we && tbl_hit && !pass_once &&
         !((state_q == RS_STEP) && step_reached))
        |=> ((state_q == RS_HALTED) && stat_hw_bp));

    p_pass_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_valid && active && hw_flag_q && (pc == brk_q) &&
         !((state_q == RS_STEP) && step_reached)) |-> exec_en);

    p_evt_halts_r12: assert property (@(posedge clk) disable iff (!rst_n)
        halt_evt |=> (state_q == RS_HALTED));
endmodule

// File: tb/dbg_runctl_test.sv
`timescale 1ns/100ps
module dbg_runctl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ctl_we, ctl_halt, ctl_step;
    logic [63:0] step_len;
    logic        bp_add_we, bp_rm_we;
    logic [31:0] bp_add_addr, bp_rm_addr;
    logic        slot_valid, sw_bp_hit;
    logic [31:0] pc;
    logic        exec_en, halt_evt, stat_halt, stat_sw_bp, stat_hw_bp;
    logic [63:0] step_count;

    int n_chk = 0;
    int n_fail = 0;
    logic got_exec, got_evt;

    always #2.5 clk = ~clk;

    dbg_runctl uut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_halt(ctl_halt),
        .ctl_step(ctl_step), .step_len(step_len), .bp_add_we(bp_add_we),
        .bp_add_addr(bp_add_addr), .bp_rm_we(bp_rm_we), .bp_rm_addr(bp_rm_addr),
        .slot_valid(slot_valid), .pc(pc), .sw_bp_hit(sw_bp_hit),
        .exec_en(exec_en), .halt_evt(halt_evt), .stat_halt(stat_halt),
        .stat_sw_bp(stat_sw_bp), .stat_hw_bp(stat_hw_bp), .step_count(step_count)
    );

    // {op[1:0], pc[15:0], exp_exec, exp_stat_halt}; op 0 slot, 1 go, 2 step, 3 halt
    localparam int NV = 18;
    localparam logic [19:0] VEC [NV] = '{
        {2'd0, 16'h0010, 1'b0, 1'b1},
        {2'd1, 16'h0000, 1'b0, 1'b0},
        {2'd0, 16'h0010, 1'b1, 1'b0},
        {2'd0, 16'h0014, 1'b1, 1'b0},
        {2'd0, 16'h0040, 1'b0, 1'b1},
        {2'd1, 16'h0000, 1'b0, 1'b0},
        {2'd0, 16'h0040, 1'b1, 1'b0},
        {2'd0, 16'h0044, 1'b1, 1'b0},
        {2'd0, 16'h0080, 1'b0, 1'b1},
        {2'd2, 16'h0000, 1'b0, 1'b0},
        {2'd0, 16'h0080, 1'b1, 1'b0},
        {2'd0, 16'h0084, 1'b1, 1'b0},
        {2'd0, 16'h0088, 1'b0, 1'b1},
        {2'd1, 16'h0000, 1'b0, 1'b0},
        {2'd0, 16'h0040, 1'b0, 1'b1},
        {2'd1, 16'h0000, 1'b0, 1'b0},
        {2'd0, 16'h0040, 1'b1, 1'b0},
        {2'd3, 16'h0000, 1'b0, 1'b1}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic edge_step();
        @(posedge clk);
        #1;
    endtask

    task automatic ctl(input logic h, input logic s);
        ctl_we = 1'b1; ctl_halt = h; ctl_step = s;
        #1;
        got_evt = halt_evt;
        edge_step();
        ctl_we = 1'b0; ctl_halt = 1'b0; ctl_step = 1'b0;
    endtask

    task automatic slot(input logic [31:0] a, input logic swb);
        slot_valid = 1'b1; pc = a; sw_bp_hit = swb;
        #1;
        got_exec = exec_en;
        got_evt  = halt_evt;
        edge_step();
        slot_valid = 1'b0; sw_bp_hit = 1'b0;
    endtask

    task automatic bp_add(input logic [31:0] a);
        bp_add_we = 1'b1; bp_add_addr = a;
        edge_step();
        bp_add_we = 1'b0;
    endtask

    task automatic bp_rm(input logic [31:0] a);
        bp_rm_we = 1'b1; bp_rm_addr = a;
        edge_step();
        bp_rm_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; ctl_we = 0; ctl_halt = 0; ctl_step = 0; step_len = 64'd2;
        bp_add_we = 0; bp_rm_we = 0; bp_add_addr = '0; bp_rm_addr = '0;
        slot_valid = 0; pc = '0; sw_bp_hit = 0;
        edge_step(); edge_step();

        // R1 reset state, slot offered while off
        slot_valid = 1'b1; pc = 32'h10;
        #1;
        check("R1 exec_en in reset", exec_en, 0);
        check("R1 stat_halt in reset", stat_halt, 1);
        check("R1 count in reset", step_count, 0);
        check("R1 flags in reset", {stat_sw_bp, stat_hw_bp}, 0);
        slot_valid = 1'b0;
        edge_step();

        // R3 go presented on the off cycle is ignored
        rst_n = 1'b1;
        ctl_we = 1'b1;
        edge_step();
        ctl_we = 1'b0;
        edge_step();
        check("R3 still halted after off-cycle go", stat_halt, 1);

        bp_add(32'h40);
        bp_add(32'h80);

        // R4 R6 R7 R8 vector walk
        for (int i = 0; i < NV; i++) begin
            logic [19:0] v;
            v = VEC[i];
            case (v[19:18])
                2'd0: begin
                    slot({16'h0, v[17:2]}, 1'b0);
                    check($sformatf("R4/R6/R7/R8 vec%0d exec", i), got_exec, v[1]);
                end
                2'd1: ctl(1'b0, 1'b0);
                2'd2: ctl(1'b0, 1'b1);
                default: ctl(1'b1, 1'b0);
            endcase
            check($sformatf("R2/R6/R7 vec%0d halt", i), stat_halt, v[0]);
        end
        check("R5 count after walk", step_count, 7);
        check("R8 hw flag cleared by pass", stat_hw_bp, 0);

        // R2 priority, R6 zero-length step
        ctl(1'b1, 1'b1);
        check("R2 halt wins over step", stat_halt, 1);
        step_len = 64'd0;
        ctl(1'b0, 1'b1);
        check("R2 step entered", stat_halt, 0);
        slot(32'h500, 1'b0);
        check("R6 zero step no exec", got_exec, 0);
        check("R12 evt on step stop", got_evt, 1);
        check("R6 halted after zero step", stat_halt, 1);
        check("R5 count held", step_count, 7);

        // R12 halt write from run vs from halted
        ctl(1'b0, 1'b0);
        ctl(1'b1, 1'b0);
        check("R12 evt on halt write from run", got_evt, 1);
        ctl(1'b1, 1'b0);
        check("R12 no evt when already halted", got_evt, 0);

        // R13 control write with breakpoint hit in same cycle
        ctl(1'b0, 1'b0);
        ctl_we = 1'b1;
        slot(32'h40, 1'b0);
        ctl_we = 1'b0;
        check("R13 bp slot not executed", got_exec, 0);
        check("R13 control decides state", stat_halt, 0);
        check("R7 hw flag set", stat_hw_bp, 1);
        slot(32'h40, 1'b0);
        check("R8 pass once", got_exec, 1);
        slot(32'h44, 1'b0);

        // R11 software breakpoint
        slot(32'h48, 1'b1);
        check("R11 sw slot executes", got_exec, 1);
        check("R11 evt", got_evt, 1);
        check("R11 halted", stat_halt, 1);
        check("R11 sw flag set", stat_sw_bp, 1);
        ctl(1'b0, 1'b0);
        check("R11 sw flag cleared by go", stat_sw_bp, 0);

        // R9 fill and overfill
        for (int k = 0; k < 6; k++) bp_add(32'h100 + 32'(k * 4));
        bp_add(32'h200);
        slot(32'h200, 1'b0);
        check("R9 add to full table dropped", got_exec, 1);
        slot(32'h114, 1'b0);
        check("R9 eighth entry active", got_exec, 0);
        ctl(1'b0, 1'b0);
        slot(32'h114, 1'b0);

        // R10 remove and duplicates
        bp_rm(32'h40);
        slot(32'h40, 1'b0);
        check("R10 removed entry inactive", got_exec, 1);
        bp_add(32'h300);
        bp_rm(32'h80);
        bp_add(32'h300);
        bp_rm(32'h300);
        slot(32'h300, 1'b0);
        check("R10 duplicate still active", got_exec, 0);
        check("R5 count live", step_count, 13);

        // R1 reset clears flags
        rst_n = 1'b0;
        #1;
        check("R1 reset clears hw flag", stat_hw_bp, 0);
        check("R1 reset forces off", stat_halt, 1);
        check("R1 reset clears count", step_count, 0);
        finish_run();
    end
endmodule